// File: doc/BRIEF.md
# Flash Base Decoder with Backdoor Alias

This block sits between the bus fabric and an on-chip flash array and decides, for each bus request, whether it reaches the flash and through which address window. A programmable flash base register carries a base field and a valid bit. The register places a 512 KB direct window for core reads. A second, writable peripheral base register locates a backdoor alias 0x0400_0000 above the peripheral base. Bus masters other than the core must use the alias, and so must core writes during programming. A request that breaks this rule raises an access error and is not routed.

For every accepted request the block reports which window hit, the offset inside the array, and, through a small wait-state state machine, a one-cycle data-valid pulse. Backdoor responses arrive two cycles later than direct ones. At reset only the valid bit is set from the boot configuration pins and the security flag. The base field keeps its value, except that the default configuration (reset-config pin not asserted) clears it to 0x0.

The wait-state machine has three states. S_IDLE accepts a request. S_WAIT counts down the extra cycles. S_RESP drives the data-valid pulse. The transitions are: IDLE->RESP (start with a wait count of zero), IDLE->WAIT (start with a nonzero wait count), WAIT->WAIT (count above one), WAIT->RESP (count reaches one), RESP->IDLE (always), and IDLE->IDLE (no routed request).

Top module: `flash_base_decoder`

## Requirements
- R1: The valid bit is sampled while reset is held. With `cfg_rcon`=1, `sec_locked`=0, it comes out of reset set if and only if `cfg_mode`=3'b110, or `cfg_mode`=3'b111 with `cfg_boot`=2'b00.
- R2: With `cfg_rcon`=0 during reset, the valid bit comes out set and the base field is cleared, so `fbar_q` reads 32'h0000_0001.
- R3: With `sec_locked`=1 during reset, the valid bit comes out set whatever the other configuration pins show.
- R4: A reset with `cfg_rcon`=1 leaves the base field at its previous value.
- R5: A direct hit needs `acc_core`=1, `acc_write`=0, the valid bit set, and `acc_addr[31:19]` equal to the base field. The offset is then `acc_addr[18:0]`.
- R6: While the valid bit is clear, the direct window gives neither a hit nor an error.
- R7: The backdoor window covers the 512 KB that start at `pbar_q`+0x0400_0000. It serves any master, read or write, and follows writes to the peripheral base. Its offset is the address minus that start. If the two windows overlap, the backdoor wins.
- R8: A non-core access, or a core write, that falls in the enabled direct window raises `acc_err` and gets no `rdy`.
- R9: `rdy` pulses for one cycle. For a direct hit it comes 1 cycle after the request cycle. For a backdoor hit it comes 3 cycles after, which is 2 cycles more. A miss gets no `rdy`.
- R10: While `busy`=1, requests are ignored: no hit or error flag is raised and the pending response is unchanged.
- R11: Register writes use `reg_sel`=0 for the flash base register (bits 31:19 base, bit 0 valid, other bits read 0) and `reg_sel`=1 for the full 32-bit peripheral base, which resets to 32'h4000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rcon | input | 1 | Reset-config pin asserted |
| cfg_mode | input | 3 | Boot mode pins |
| cfg_boot | input | 2 | Boot-select pins |
| sec_locked | input | 1 | Flash security flag read during reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = flash base register, 1 = peripheral base register |
| reg_wdata | input | 32 | Register write data |
| fbar_q | output | 32 | Flash base register value |
| pbar_q | output | 32 | Peripheral base register value |
| acc_req | input | 1 | Bus request valid |
| acc_addr | input | 32 | Request address |
| acc_write | input | 1 | Request is a write |
| acc_core | input | 1 | Request comes from the CPU core |
| hit_direct | output | 1 | Routed through the direct window |
| hit_backdoor | output | 1 | Routed through the backdoor alias |
| acc_err | output | 1 | Access error: wrong master or direction for the direct window |
| arr_offset | output | 19 | Offset into the flash array |
| busy | output | 1 | A response is pending |
| rdy | output | 1 | Data-valid pulse |

## Verification
The bench builds the block with its default parameters. These are a 19-bit window (512 KB), a backdoor offset of 0x0400_0000, a peripheral base reset value of 0x4000_0000, no direct wait state and two extra backdoor wait states. With these values both window edges, the overlap rule and the two-cycle latency gap can all be reached with addresses written directly. The table sweeps window edges, master type and direction against the reset base. Directed tests then cover a moved peripheral base, a cleared valid bit, each boot pin pattern, the security override, base retention across reset, and requests made while busy.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_RESP = 2'd2
    } fbd_state_e;
endpackage

// File: rtl/fbd_regs.sv
module fbd_regs #(
    parameter int AW       = 32,
    parameter int WIN_LOG2 = 19,
    parameter logic [31:0] PBAR_RST = 32'h4000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_rcon,
    input  logic [2:0]    cfg_mode,
    input  logic [1:0]    cfg_boot,
    input  logic          sec_locked,
    input  logic          reg_we,
    input  logic          reg_sel,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] fbar_q,
    output logic [AW-1:0] pbar_q,
    output logic [AW-WIN_LOG2-1:0] base_q,
    output logic          valid_q
);
    localparam int BW = AW - WIN_LOG2;

    logic boot_valid;

    // Valid-at-reset decode: security override, default config, two pin patterns
    always_comb begin
        boot_valid = 1'b0;
        if (sec_locked || !cfg_rcon)
            boot_valid = 1'b1;
        else if (cfg_mode == 3'b110)
            boot_valid = 1'b1;
        else if (cfg_mode == 3'b111 && cfg_boot == 2'b00)
            boot_valid = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            valid_q <= boot_valid;
        else if (reg_we && !reg_sel)
            valid_q <= reg_wdata[0];
    end

    // Base field only clears in default configuration; otherwise it keeps its value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            if (!cfg_rcon)
                base_q <= '0;
        end else if (reg_we && !reg_sel) begin
            base_q <= reg_wdata[AW-1:WIN_LOG2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pbar_q <= PBAR_RST[AW-1:0];
        else if (reg_we && reg_sel)
            pbar_q <= reg_wdata;
    end

    assign fbar_q = {base_q, {(WIN_LOG2-1){1'b0}}, valid_q};

    AST_PBAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel) |=> (pbar_q == $past(reg_wdata))) else $error("pbar write"); // R11
    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(base_q)) else $error("base hold"); // R4

    logic unused_bw;
    assign unused_bw = (BW == 0);
endmodule

// File: rtl/fbd_decode.sv
module fbd_decode #(
    parameter int AW       = 32,
    parameter int WIN_LOG2 = 19,
    parameter logic [31:0] BD_OFS = 32'h0400_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [AW-1:0] acc_addr,
    input  logic          acc_write,
    input  logic          acc_core,
    input  logic [AW-WIN_LOG2-1:0] base_q,
    input  logic          valid_q,
    input  logic [AW-1:0] pbar_q,
    output logic          hit_direct,
    output logic          hit_backdoor,
    output logic          acc_err,
    output logic [WIN_LOG2-1:0] arr_offset
);
    logic [AW-1:0] bd_start;
    logic [AW-1:0] bd_diff;
    logic          in_bd;
    logic          in_dir;
    logic          dir_allowed;

    always_comb begin
        bd_start    = pbar_q + BD_OFS[AW-1:0];
        bd_diff     = acc_addr - bd_start;
        in_bd       = (bd_diff[AW-1:WIN_LOG2] == '0);
        in_dir      = valid_q && (acc_addr[AW-1:WIN_LOG2] == base_q);
        dir_allowed = acc_core && !acc_write;

        hit_backdoor = take && in_bd;
        hit_direct   = take && !in_bd && in_dir && dir_allowed;
        acc_err      = take && !in_bd && in_dir && !dir_allowed;
        arr_offset   = in_bd ? bd_diff[WIN_LOG2-1:0] : acc_addr[WIN_LOG2-1:0];
    end

    AST_DIRECT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        hit_direct |-> valid_q) else $error("direct without valid"); // R6
    AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_direct, hit_backdoor, acc_err})) else $error("routes"); // R7
    AST_ERR_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (!acc_core || acc_write)) else $error("err on core read"); // R8
endmodule

// File: rtl/fbd_timer.sv
module fbd_timer
    import fbd_pkg::*;
#(
    parameter int DIR_WAIT = 0,
    parameter int BD_EXTRA = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_bd,
    output logic busy,
    output logic rdy
);
    localparam int MAXW = DIR_WAIT + BD_EXTRA;
    localparam int CW   = $clog2(MAXW + 2);
    localparam logic [CW-1:0] W_DIR = CW'(DIR_WAIT);
    localparam logic [CW-1:0] W_BD  = CW'(MAXW);

    fbd_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] load_w;

    assign load_w = start_bd ? W_BD : W_DIR;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_IDLE: if (start) begin
                cnt_d   = load_w;
                state_d = (load_w == '0) ? S_RESP : S_WAIT;
            end
            S_WAIT: begin
                cnt_d = cnt_q - 1'b1;
                if (cnt_q == CW'(1))
                    state_d = S_RESP;
            end
            S_RESP: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        busy = (state_q != S_IDLE);
        rdy  = (state_q == S_RESP);
    end

    AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy) else $error("rdy too long"); // R9
    AST_BD_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (start && start_bd && !busy) |=> !rdy) else $error("backdoor too fast"); // R9
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT) |=> (state_q != S_IDLE)) else $error("wait dropped"); // R10
endmodule

// File: rtl/flash_base_decoder.sv
module flash_base_decoder
    import fbd_pkg::*;
#(
    parameter int AW       = 32,
    parameter int WIN_LOG2 = 19,
    parameter logic [31:0] BD_OFS   = 32'h0400_0000,
    parameter logic [31:0] PBAR_RST = 32'h4000_0000,
    parameter int DIR_WAIT = 0,
    parameter int BD_EXTRA = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_rcon,
    input  logic [2:0]          cfg_mode,
    input  logic [1:0]          cfg_boot,
    input  logic                sec_locked,
    input  logic                reg_we,
    input  logic                reg_sel,
    input  logic [AW-1:0]       reg_wdata,
    output logic [AW-1:0]       fbar_q,
    output logic [AW-1:0]       pbar_q,
    input  logic                acc_req,
    input  logic [AW-1:0]       acc_addr,
    input  logic                acc_write,
    input  logic                acc_core,
    output logic                hit_direct,
    output logic                hit_backdoor,
    output logic                acc_err,
    output logic [WIN_LOG2-1:0] arr_offset,
    output logic                busy,
    output logic                rdy
);
    logic [AW-WIN_LOG2-1:0] base_q;
    logic                   valid_q;
    logic                   take;

    assign take = acc_req && !busy;

    fbd_regs #(.AW(AW), .WIN_LOG2(WIN_LOG2), .PBAR_RST(PBAR_RST)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_rcon(cfg_rcon), .cfg_mode(cfg_mode), .cfg_boot(cfg_boot),
        .sec_locked(sec_locked),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .fbar_q(fbar_q), .pbar_q(pbar_q), .base_q(base_q), .valid_q(valid_q)
    );

    fbd_decode #(.AW(AW), .WIN_LOG2(WIN_LOG2), .BD_OFS(BD_OFS)) u_dec (
        .clk(clk), .rst_n(rst_n), .take(take),
        .acc_addr(acc_addr), .acc_write(acc_write), .acc_core(acc_core),
        .base_q(base_q), .valid_q(valid_q), .pbar_q(pbar_q),
        .hit_direct(hit_direct), .hit_backdoor(hit_backdoor),
        .acc_err(acc_err), .arr_offset(arr_offset)
    );

    fbd_timer #(.DIR_WAIT(DIR_WAIT), .BD_EXTRA(BD_EXTRA)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .start(hit_direct || hit_backdoor), .start_bd(hit_backdoor),
        .busy(busy), .rdy(rdy)
    );

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(hit_direct || hit_backdoor || acc_err)) else $error("busy routed"); // R10
    AST_ERR_NO_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_err && !busy) |=> !busy) else $error("err started"); // R8
endmodule

// File: tb/tb_flash_base_decoder.sv
module tb_flash_base_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rcon = 1'b0;
    logic [2:0]  cfg_mode = 3'b000;
    logic [1:0]  cfg_boot = 2'b00;
    logic        sec_locked = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] fbar_q, pbar_q;
    logic        acc_req = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        acc_core = 1'b0;
    logic        hit_direct, hit_backdoor, acc_err, busy, rdy;
    logic [18:0] arr_offset;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    flash_base_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_rcon(cfg_rcon), .cfg_mode(cfg_mode),
        .cfg_boot(cfg_boot), .sec_locked(sec_locked), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .fbar_q(fbar_q), .pbar_q(pbar_q),
        .acc_req(acc_req), .acc_addr(acc_addr), .acc_write(acc_write),
        .acc_core(acc_core), .hit_direct(hit_direct), .hit_backdoor(hit_backdoor),
        .acc_err(acc_err), .arr_offset(arr_offset), .busy(busy), .rdy(rdy)
    );

    // {addr, core, write, exp_dir, exp_bd, exp_err, exp_off, exp_lat}
    localparam logic [58:0] VEC [10] = '{
        {32'h0000_0010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 19'h00010, 3'd1},
        {32'h0007_FFFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 19'h7FFFF, 3'd1},
        {32'h0008_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 19'h00000, 3'd0},
        {32'h0000_0100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 19'h00100, 3'd0},
        {32'h0000_0100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 19'h00100, 3'd0},
        {32'h4400_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 19'h00000, 3'd3},
        {32'h4400_0004, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 19'h00004, 3'd3},
        {32'h4407_FFFC, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 19'h7FFFC, 3'd3},
        {32'h4408_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 19'h00000, 3'd0},
        {32'h43FF_FFFC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 19'h00000, 3'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic rc, input logic [2:0] md, input logic [1:0] bt, input logic sc);
        @(negedge clk);
        cfg_rcon = rc; cfg_mode = md; cfg_boot = bt; sec_locked = sc;
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        cfg_rcon = 1'b0; cfg_mode = 3'b000; cfg_boot = 2'b00; sec_locked = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic access(input string req, input logic [31:0] a, input logic c, input logic w,
                          input logic ed, input logic eb, input logic ee,
                          input logic [18:0] eo, input int el);
        int n;
        @(negedge clk);
        acc_req = 1'b1; acc_addr = a; acc_core = c; acc_write = w;
        #1;
        check(req, {29'd0, hit_direct, hit_backdoor, acc_err}, {29'd0, ed, eb, ee});
        if (ed || eb) check(req, {13'd0, arr_offset}, {13'd0, eo});
        @(negedge clk);
        acc_req = 1'b0;
        n = 1;
        while (!rdy && n < 6) begin
            @(negedge clk);
            n++;
        end
        check({req, " latency"}, rdy ? n : 0, el);
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        // Reset state, default config
        do_reset(1'b0, 3'b000, 2'b00, 1'b0);
        check("R2 fbar after default reset", fbar_q, 32'h0000_0001);
        check("R11 pbar reset", pbar_q, 32'h4000_0000);
        check("R9 idle after reset", {30'd0, busy, rdy}, 32'd0);

        // Table walk: R5 R7 R8 R9
        for (int i = 0; i < 10; i++) begin
            access($sformatf("R5/R7/R8/R9 vec%0d", i), VEC[i][58:27], VEC[i][26], VEC[i][25],
                   VEC[i][24], VEC[i][23], VEC[i][22], VEC[i][21:3], int'(VEC[i][2:0]));
        end

        // R7: backdoor follows peripheral base writes
        wr_reg(1'b1, 32'h5000_0000);
        check("R11 pbar write", pbar_q, 32'h5000_0000);
        access("R7 moved alias", 32'h5400_0010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 19'h00010, 3);
        access("R7 old alias gone", 32'h4400_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 19'h0, 0);

        // R7: overlap, backdoor wins (alias at 0x0000_0000)
        wr_reg(1'b1, 32'hFC00_0000);
        access("R7 overlap priority", 32'h0000_0020, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 19'h00020, 3);
        wr_reg(1'b1, 32'h4000_0000);

        // R6/R11: base write with valid clear
        wr_reg(1'b0, 32'h0017_FFFE);
        check("R11 fbar format", fbar_q, 32'h0010_0000);
        access("R6 invalid read", 32'h0010_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 19'h0, 0);
        access("R6 invalid noncore", 32'h0010_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 19'h0, 0);
        wr_reg(1'b0, 32'h0010_0001);
        access("R5 new base", 32'h0010_0040, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 19'h00040, 1);
        access("R5 old base miss", 32'h0000_0040, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 19'h0, 0);

        // R10: request during busy ignored
        @(negedge clk);
        acc_req = 1'b1; acc_addr = 32'h4400_0000; acc_core = 1'b0; acc_write = 1'b0;
        @(negedge clk);
        acc_addr = 32'h0010_0000; acc_core = 1'b1;
        #1;
        check("R10 busy flags", {29'd0, hit_direct, hit_backdoor, acc_err}, 32'd0);
        @(negedge clk);
        acc_req = 1'b0;
        check("R10 no early rdy", {31'd0, rdy}, 32'd0);
        @(negedge clk);
        check("R10 pending rdy", {31'd0, rdy}, 32'd1);
        @(negedge clk);
        check("R10 back idle", {30'd0, busy, rdy}, 32'd0);

        // R1/R4: boot pin patterns, base retained
        do_reset(1'b1, 3'b000, 2'b00, 1'b0);
        check("R1 mode 000 invalid, R4 base kept", fbar_q, 32'h0010_0000);
        do_reset(1'b1, 3'b110, 2'b11, 1'b0);
        check("R1 mode 110 valid", fbar_q, 32'h0010_0001);
        do_reset(1'b1, 3'b111, 2'b00, 1'b0);
        check("R1 mode 111 boot 00 valid", fbar_q, 32'h0010_0001);
        do_reset(1'b1, 3'b111, 2'b01, 1'b0);
        check("R1 mode 111 boot 01 invalid", fbar_q, 32'h0010_0000);
        do_reset(1'b1, 3'b111, 2'b01, 1'b1);
        check("R3 security forces valid", fbar_q, 32'h0010_0001);
        do_reset(1'b1, 3'b010, 2'b10, 1'b1);
        check("R3 security forces valid 2", fbar_q, 32'h0010_0001);
        access("R3 secured direct read", 32'h0010_0008, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 19'h00008, 1);
        do_reset(1'b0, 3'b111, 2'b01, 1'b0);
        check("R2 default clears base", fbar_q, 32'h0000_0001);
        access("R2 direct at zero", 32'h0000_0004, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 19'h00004, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule